// File: doc/BRIEF.md
# Shadowed Single-Channel PWM Generator

This block drives one pulse-width-modulated output from a 32-bit time-stamp counter. A small register bus sets the period and the compare value, both counted in clock cycles, and a 16-bit control word turns on the counter, the output and the polarity. The counter runs from 0 to period minus 1 and wraps. With normal polarity the output is high while the count is below the compare value. With low polarity the compare value sets the low time instead.

Software can write the period and compare registers two ways. A direct write to an active register takes effect on the next clock. A write to a shadow register is held back and copied into the active pair on the cycle the counter wraps. The period that is running therefore finishes unchanged, and the waveform never shows a glitch.

Top module: `aux_pwm_gen`

## Requirements
- R1: While rst_ni is low, every register, the counter and rdata_o are cleared and pwm_o is low. After reset, every register reads 0.
- R2: Byte addresses on addr_i: active period 0x08, active compare 0x0C, shadow period 0x10, shadow compare 0x14, control 0x2A. A write with wr_en_i lands at the next rising edge. Control keeps wdata_i[15:0] only and reads back zero-extended. With rd_en_i, rdata_o is loaded at the next edge with the value the addressed register held before that edge, and it holds otherwise. Unmapped addresses read 0 and ignore writes.
- R3: Control bit 4 = 1 makes the counter advance by 1 per cycle from 0 to active period − 1 and then wrap to 0. Control bit 4 = 0 holds the counter.
- R4: Control bit 9 = 0 forces pwm_o low whatever the counter, compare value and polarity are.
- R5: With bit 9 = 1 and bit 10 = 0, pwm_o is high exactly while count < active compare. A compare of 0 gives constant low. A compare of period or more gives constant high.
- R6: With bit 9 = 1 and bit 10 = 1, pwm_o is low exactly while count < active compare and high otherwise.
- R7: Shadow writes do not touch the active registers until a wrap. On the wrap cycle, both shadow values are copied to the active pair only if a shadow write has happened since the last copy. A shadow write on the wrap cycle itself keeps the copy pending for the next wrap, and that cycle's copy, if one was already due, uses the older shadow values.
- R8: A direct write to an active register takes effect at the next edge and wins over a shadow copy in the same cycle.
- R9: Period 1 with compare 1 keeps the counter at 0 and gives constant high with normal polarity. Period 0 behaves like period 1.
- R10: Control bits other than 4, 9 and 10 (including sync-select bits 7:6) are stored and read back but have no effect on pwm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | 1 | PWM output |

## Verification
The output is tried with a mid-range compare under both polarities, which shows whether the high time and the low time are swapped. It is also tried with compare 0 and with compare above the period, which separates a strict comparison from an inclusive one at the ends. Shadow updates are written in the middle of a period and then read back before and after the wrap, so an early copy is told apart from a correct deferred one. A long random mix of direct writes, shadow writes and control changes lands writes on wrap cycles, which tests the ordering between the pending flag and the copy against a cycle-by-cycle reference model.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_APER = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ACMP = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_SPER = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_SCMP = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h2A;

  localparam int RUN_BIT     = 4;
  localparam int OUT_EN_BIT  = 9;
  localparam int POL_LOW_BIT = 10;

  // slot index inside the active/shadow pair array
  localparam int SLOT_PER = 0;
  localparam int SLOT_CMP = 1;
  localparam int NSLOT    = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_APER,
    SEL_ACMP,
    SEL_SPER,
    SEL_SCMP,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_APER: s = SEL_APER;
      OFS_ACMP: s = SEL_ACMP;
      OFS_SPER: s = SEL_SPER;
      OFS_SCMP: s = SEL_SCMP;
      OFS_CTRL: s = SEL_CTRL;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/aux_pwm_slot.sv
module aux_pwm_slot #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_we_i,
  input  logic         shd_we_i,
  input  logic         xfer_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] shd_o
);

  logic [W-1:0] act_q, shd_q;

  // direct write outranks the wrap copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_we_i) begin
      act_q <= wdata_i;
    end else if (xfer_i) begin
      act_q <= shd_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
    end else if (shd_we_i) begin
      shd_q <= wdata_i;
    end
  end

  assign act_o = act_q;
  assign shd_o = shd_q;

endmodule

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              wrap_i,
  output logic [CNT_W-1:0]  act_per_o,
  output logic [CNT_W-1:0]  act_cmp_o,
  output logic [CNT_W-1:0]  shd_per_o,
  output logic              run_o,
  output logic              out_en_o,
  output logic              pol_low_o,
  output logic              pending_o,
  output logic [CNT_W-1:0]  rdata_o
);

  reg_sel_e          sel;
  logic [NSLOT-1:0]  act_we, shd_we;
  logic [CNT_W-1:0]  act_q [NSLOT];
  logic [CNT_W-1:0]  shd_q [NSLOT];
  logic              pending_q, xfer;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  rd_mux, rdata_q;

  assign sel = decode_sel(addr_i);

  always_comb begin
    act_we = '0;
    shd_we = '0;
    if (wr_en_i) begin
      case (sel)
        SEL_APER: act_we[SLOT_PER] = 1'b1;
        SEL_ACMP: act_we[SLOT_CMP] = 1'b1;
        SEL_SPER: shd_we[SLOT_PER] = 1'b1;
        SEL_SCMP: shd_we[SLOT_CMP] = 1'b1;
        default:  ;
      endcase
    end
  end

  assign xfer = wrap_i & pending_q;

  // a shadow write on a wrap cycle re-arms the flag for the next wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pending_q <= 1'b0;
    else if (|shd_we)   pending_q <= 1'b1;
    else if (wrap_i)    pending_q <= 1'b0;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    aux_pwm_slot #(.W(CNT_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_we_i (act_we[k]),
      .shd_we_i (shd_we[k]),
      .xfer_i   (xfer),
      .wdata_i  (wdata_i),
      .act_o    (act_q[k]),
      .shd_o    (shd_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (wr_en_i && sel == SEL_CTRL)  ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_comb begin
    case (sel)
      SEL_APER: rd_mux = act_q[SLOT_PER];
      SEL_ACMP: rd_mux = act_q[SLOT_CMP];
      SEL_SPER: rd_mux = shd_q[SLOT_PER];
      SEL_SCMP: rd_mux = shd_q[SLOT_CMP];
      SEL_CTRL: rd_mux = CNT_W'(ctrl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign act_per_o = act_q[SLOT_PER];
  assign act_cmp_o = act_q[SLOT_CMP];
  assign shd_per_o = shd_q[SLOT_PER];
  assign run_o     = ctrl_q[RUN_BIT];
  assign out_en_o  = ctrl_q[OUT_EN_BIT];
  assign pol_low_o = ctrl_q[POL_LOW_BIT];
  assign pending_o = pending_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/aux_pwm_timebase.sv
module aux_pwm_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  // one extra bit so period 0 and full-scale counts compare cleanly
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap_o  = run_i && (cnt_inc >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_inc[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/aux_pwm_wave.sv
module aux_pwm_wave #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             out_en_i,
  input  logic             pol_low_i,
  output logic             pwm_o
);

  logic below;

  assign below = cnt_i < cmp_i;
  assign pwm_o = out_en_i & (below ^ pol_low_i);

endmodule

// File: rtl/aux_pwm_gen.sv
module aux_pwm_gen
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              pwm_o
);

  logic [CNT_W-1:0] act_per_w, act_cmp_w, shd_per_w, cnt_w;
  logic             run_w, out_en_w, pol_low_w, pending_w, wrap_w;

  aux_pwm_regs #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wrap_i    (wrap_w),
    .act_per_o (act_per_w),
    .act_cmp_o (act_cmp_w),
    .shd_per_o (shd_per_w),
    .run_o     (run_w),
    .out_en_o  (out_en_w),
    .pol_low_o (pol_low_w),
    .pending_o (pending_w),
    .rdata_o   (rdata_o)
  );

  aux_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .period_i (act_per_w),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  aux_pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .cnt_i     (cnt_w),
    .cmp_i     (act_cmp_w),
    .out_en_i  (out_en_w),
    .pol_low_i (pol_low_w),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/aux_pwm_gen_chk.sv
module aux_pwm_gen_chk
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pwm_i,
  input logic              run_i,
  input logic              out_en_i,
  input logic              wrap_i,
  input logic              pending_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  act_per_i,
  input logic [CNT_W-1:0]  shd_per_i
);

  logic per_wr;
  assign per_wr = wr_en_i && (addr_i == OFS_APER);

  // R4
  out_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> !pwm_i);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  // R7
  shadow_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && pending_i && !per_wr) |=> (act_per_i == $past(shd_per_i)));

  // R7
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_wr && !(wrap_i && pending_i)) |=> $stable(act_per_i));

endmodule

bind aux_pwm_gen aux_pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .pwm_i     (pwm_o),
  .run_i     (run_w),
  .out_en_i  (out_en_w),
  .wrap_i    (wrap_w),
  .pending_i (pending_w),
  .cnt_i     (cnt_w),
  .act_per_i (act_per_w),
  .shd_per_i (shd_per_w)
);

// File: tb/aux_pwm_gen_test.sv
module aux_pwm_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  localparam logic [5:0] A_APER = 6'h08;
  localparam logic [5:0] A_ACMP = 6'h0C;
  localparam logic [5:0] A_SPER = 6'h10;
  localparam logic [5:0] A_SCMP = 6'h14;
  localparam logic [5:0] A_CTRL = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    chk_on = 1'b0;
  string cur_tag = "R1";

  // reference model state
  longint unsigned m_cnt, m_per, m_cmp, m_sper, m_scmp, m_ctrl, m_rdata;
  bit m_pend;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aux_pwm_gen uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned m_read(input logic [5:0] a);
    case (a)
      A_APER:  return m_per;
      A_ACMP:  return m_cmp;
      A_SPER:  return m_sper;
      A_SCMP:  return m_scmp;
      A_CTRL:  return m_ctrl;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_out();
    bit high;
    high = (m_cnt < m_cmp);
    if (m_ctrl[10]) high = !high;
    return m_ctrl[9] ? high : 1'b0;
  endfunction

  always @(posedge clk) begin
    longint unsigned n_cnt, n_per, n_cmp;
    bit wrap, sh_wr;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_cmp = 0; m_sper = 0; m_scmp = 0;
      m_ctrl = 0; m_rdata = 0; m_pend = 0;
    end else begin
      wrap  = m_ctrl[4] && (m_cnt + 1 >= m_per);
      n_cnt = !m_ctrl[4] ? m_cnt : (wrap ? 0 : m_cnt + 1);
      n_per = m_per;
      n_cmp = m_cmp;
      if (wrap && m_pend) begin
        n_per = m_sper;
        n_cmp = m_scmp;
      end
      if (rd_en) m_rdata = m_read(addr);
      sh_wr = 1'b0;
      if (wr_en) begin
        case (addr)
          A_APER: n_per = wdata;
          A_ACMP: n_cmp = wdata;
          A_SPER: begin m_sper = wdata; sh_wr = 1'b1; end
          A_SCMP: begin m_scmp = wdata; sh_wr = 1'b1; end
          A_CTRL: m_ctrl = wdata & 32'h0000_FFFF;
          default: ;
        endcase
      end
      if (sh_wr)     m_pend = 1'b1;
      else if (wrap) m_pend = 1'b0;
      m_cnt = n_cnt;
      m_per = n_per;
      m_cmp = n_cmp;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk({cur_tag, " pwm_o vs model"}, {63'd0, pwm}, {63'd0, m_out()});
      chk("R2 rdata_o vs model", {32'd0, rdata}, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, {32'd0, rdata}, {32'd0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, input int exp, input string tag);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm === 1'b1) hi++;
      @(negedge clk);
    end
    chk(tag, hi, exp);
  endtask

  initial begin
    logic snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R1 reset state
    chk("R1 pwm_o after reset", {63'd0, pwm}, 64'd0);
    chk("R1 rdata_o after reset", {32'd0, rdata}, 64'd0);
    rd_chk(A_APER, 32'd0, "R1 active period reset");
    rd_chk(A_ACMP, 32'd0, "R1 active compare reset");
    rd_chk(A_SPER, 32'd0, "R1 shadow period reset");
    rd_chk(A_CTRL, 32'd0, "R1 control reset");

    // R2 register map
    cur_tag = "R2";
    wr(A_APER, 32'h1234_5678);
    rd_chk(A_APER, 32'h1234_5678, "R2 active period readback");
    wr(A_ACMP, 32'h0BAD_F00D);
    rd_chk(A_ACMP, 32'h0BAD_F00D, "R2 active compare readback");
    wr(A_SPER, 32'hCAFE_0001);
    rd_chk(A_SPER, 32'hCAFE_0001, "R2 shadow period readback");
    wr(A_SCMP, 32'h0000_BEEF);
    rd_chk(A_SCMP, 32'h0000_BEEF, "R2 shadow compare readback");
    wr(A_CTRL, 32'hFFFF_00C0);
    rd_chk(A_CTRL, 32'h0000_00C0, "R2 control keeps low 16 bits");
    wr(6'h20, 32'hFFFF_FFFF);
    rd_chk(6'h20, 32'd0, "R2 unmapped reads zero");
    rd_chk(A_ACMP, 32'h0BAD_F00D, "R2 unmapped write ignored");

    // R5 normal polarity
    cur_tag = "R5";
    wr(A_APER, 10); wr(A_ACMP, 3); wr(A_SPER, 10); wr(A_SCMP, 3);
    wr(A_CTRL, 32'h0210);
    idle(25);
    count_high(10, 3, "R5 high cycles per period");

    // R3 counter hold
    cur_tag = "R3";
    wr(A_CTRL, 32'h0200);
    snap = pwm;
    idle(6);
    chk("R3 output frozen while stopped", {63'd0, pwm}, {63'd0, snap});
    wr(A_CTRL, 32'h0210);
    idle(5);

    // R6 low polarity
    cur_tag = "R6";
    wr(A_CTRL, 32'h0610);
    idle(12);
    count_high(10, 7, "R6 high cycles with low polarity");

    // R5 compare boundaries
    cur_tag = "R5";
    wr(A_CTRL, 32'h0210);
    wr(A_ACMP, 0); wr(A_SCMP, 0);
    idle(12);
    count_high(10, 0, "R5 compare zero constant low");
    wr(A_ACMP, 15); wr(A_SCMP, 15);
    idle(12);
    count_high(10, 10, "R5 compare above period constant high");

    // R7 deferred shadow copy
    cur_tag = "R7";
    wr(A_ACMP, 3); wr(A_SCMP, 3);
    idle(12);
    wr(A_SPER, 4); wr(A_SCMP, 1);
    rd_chk(A_APER, 32'd10, "R7 active period unchanged before wrap");
    rd_chk(A_SPER, 32'd4, "R7 shadow period stored");
    idle(12);
    rd_chk(A_APER, 32'd4, "R7 active period copied at wrap");
    rd_chk(A_ACMP, 32'd1, "R7 active compare copied at wrap");
    count_high(8, 2, "R7 new waveform after copy");

    // R8 direct write
    cur_tag = "R8";
    wr(A_ACMP, 3);
    rd_chk(A_ACMP, 32'd3, "R8 direct compare write immediate");
    idle(4);
    count_high(8, 6, "R8 waveform after direct write");

    // R9 minimum period
    cur_tag = "R9";
    wr(A_SPER, 1); wr(A_SCMP, 1);
    idle(6);
    rd_chk(A_APER, 32'd1, "R9 period one loaded");
    count_high(5, 5, "R9 period one compare one high");
    wr(A_APER, 0); wr(A_ACMP, 1);
    idle(3);
    count_high(5, 5, "R9 period zero acts as one");

    // R4 output disabled
    cur_tag = "R4";
    wr(A_APER, 10); wr(A_ACMP, 3);
    wr(A_CTRL, 32'h0010);
    count_high(10, 0, "R4 output low with mode off");
    wr(A_CTRL, 32'h0410);
    count_high(10, 0, "R4 output low with mode off and low polarity");

    // R10 inert control bits
    cur_tag = "R10";
    wr(A_CTRL, 32'h02D1);
    rd_chk(A_CTRL, 32'h02D1, "R10 spare control bits stored");
    idle(10);
    count_high(10, 3, "R10 spare bits do not alter output");

    // R7 random mix, writes land on wrap cycles
    cur_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 15);
      wr_en = 1'b0; rd_en = 1'b0;
      case (op)
        0: begin wr_en = 1'b1; addr = A_APER; wdata = $urandom_range(0, 12); end
        1: begin wr_en = 1'b1; addr = A_ACMP; wdata = $urandom_range(0, 14); end
        2, 3: begin wr_en = 1'b1; addr = A_SPER; wdata = $urandom_range(0, 12); end
        4, 5: begin wr_en = 1'b1; addr = A_SCMP; wdata = $urandom_range(0, 14); end
        6: begin
             wr_en = 1'b1; addr = A_CTRL;
             wdata = 32'h0210 | ($urandom_range(0, 1) << 10)
                     | ($urandom_range(0, 7) == 0 ? 32'h0 : 32'h0) ;
             if ($urandom_range(0, 5) == 0) wdata[4] = 1'b0;
             if ($urandom_range(0, 5) == 0) wdata[9] = 1'b0;
           end
        7, 8: begin rd_en = 1'b1; addr = 6'($urandom_range(0, 3) * 4 + 8); end
        default: ;
      endcase
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule